// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits between the interrupt source layer and one processor. It holds one pending slot. The slot is a 32-bit pending word: a current processor priority in the top byte and a pending source number in the low 24 bits. Beside the word it keeps the priority of the pending entry and an inter-processor request priority. Smaller numbers are more favoured. A source number of zero means the slot is empty.

The source layer offers deliveries, each a source number and a priority. The presenter takes or refuses each one by comparing priorities. When a better delivery arrives, the entry it displaces goes back to its source. The processor side issues five commands: set priority, set request priority, accept, end-of-interrupt and poll. The block drives an end-of-interrupt port and a resend request towards the source layer, and one interrupt line towards the processor.

The inter-processor interrupt has no source behind it. It enters the same slot under the fixed source number 2. Every reply, pulse and response appears on the cycle after the input that caused it.

Top module: `xp_presenter`

## Requirements
- R1: After reset the pending word is 0, the request priority and the pending-entry priority are 0xFF, and the interrupt line is low. An accept right after reset therefore leaves the pending word at 0xFF000000.
- R2: A delivery whose priority is greater than or equal to the current processor priority is refused (`dlv_nak`) and changes no state.
- R3: A delivery is refused when the slot is occupied and the occupant's priority is less than or equal to the delivery's priority.
- R4: A delivery that is taken raises `dlv_ack`. The new source number and priority replace the occupant, and the interrupt line goes high. A displaced occupant that came from the source layer appears on the reject port.
- R5: The accept command (op code 3) returns the whole pending word and lowers the interrupt line. It then sets the processor priority to the pending-entry priority, empties the slot and resets the pending-entry priority to 0xFF.
- R6: The set-priority command (op 1, value in `cmd_data[7:0]`) stores the value. If the value is below the old priority, the slot is occupied and the value is at most the pending-entry priority, the slot is emptied, the line drops and a source-owned occupant is rejected.
- R7: A set-priority value that is not below the old one, given while the slot is empty, runs a resend. A resend runs the inter-processor check against the new priority and pulses `resend_req`.
- R8: The set-request-priority command (op 2, value in `cmd_data[7:0]`) stores the value. When the value is below the processor priority, the check runs. The check does nothing if an occupant's priority is at most the request priority. Otherwise it rejects any source-owned occupant, loads source number 2 with the request priority and raises the line.
- R9: The end-of-interrupt command (op 4) sets the processor priority from `cmd_data[31:24]` and pulses `eoi_valid` with `cmd_data[23:0]`. If the slot is then empty, it runs a resend.
- R10: An inter-processor entry is never sent out on the reject port.
- R11: The poll command (op 5) returns the pending word and the request priority and changes nothing.
- R12: A delivery offered in the same cycle as any command is refused, and the command executes.
- R13: Every delivery receives exactly one of `dlv_ack` or `dlv_nak` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dlv_valid | input | 1 | Delivery offered by the source layer |
| dlv_src | input | 24 | Offered source number (nonzero) |
| dlv_prio | input | 8 | Offered priority |
| dlv_ack | output | 1 | Delivery taken |
| dlv_nak | output | 1 | Delivery refused |
| rej_valid | output | 1 | Displaced source being returned |
| rej_src | output | 24 | Returned source number |
| cmd_valid | input | 1 | Processor command strobe |
| cmd_op | input | 3 | Command: 1 set priority, 2 set request priority, 3 accept, 4 end-of-interrupt, 5 poll |
| cmd_data | input | 32 | Command operand |
| rsp_valid | output | 1 | Accept or poll response |
| rsp_word | output | 32 | Pending word returned |
| rsp_mfrr | output | 8 | Request priority returned by poll |
| eoi_valid | output | 1 | End-of-interrupt to the source layer |
| eoi_src | output | 24 | Source number finished |
| resend_req | output | 1 | Ask the source layer to resend refused work |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
Two kinds of internal corruption are easy to miss. One is a wrong pending-entry priority. The other is a wrong record of whether the occupant came from the source layer or is the inter-processor entry. Neither is visible in the pending word. A bad priority first shows up one cycle after the next delivery, as an ack where a nak was due, or the reverse. A bad owner record shows up as source number 2 on the reject port, or as a lost rejection, on the cycle after the displacing event. The bench therefore polls after each state change and sweeps delivery priority against processor priority, both with the slot empty and with it occupied. A wrong state is thus exposed within one or two operations.

// File: rtl/xp_pkg.sv
package xp_pkg;
    typedef enum logic [2:0] {
        XP_OP_NONE     = 3'd0,
        XP_OP_SET_PRIO = 3'd1,
        XP_OP_SET_REQ  = 3'd2,
        XP_OP_ACCEPT   = 3'd3,
        XP_OP_EOI      = 3'd4,
        XP_OP_POLL     = 3'd5
    } xp_op_e;
endpackage

// File: rtl/xp_deliver_judge.sv
module xp_deliver_judge #(
    parameter int PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] offer_prio,
    input  logic [PRIO_W-1:0] proc_prio,
    input  logic              slot_busy,
    input  logic [PRIO_W-1:0] slot_prio,
    output logic              take
);
    logic beats_proc;
    logic beats_slot;

    always_comb begin
        beats_proc = offer_prio < proc_prio;
        beats_slot = !slot_busy || (offer_prio < slot_prio);
        take       = beats_proc && beats_slot;
    end
endmodule

// File: rtl/xp_ipi_eval.sv
module xp_ipi_eval #(
    parameter int PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] req_prio,
    input  logic [PRIO_W-1:0] proc_prio,
    input  logic              slot_busy,
    input  logic [PRIO_W-1:0] slot_prio,
    output logic              fire
);
    logic gate;
    logic held_off;

    always_comb begin
        gate     = req_prio < proc_prio;
        held_off = slot_busy && (slot_prio <= req_prio);
        fire     = gate && !held_off;
    end
endmodule

// File: rtl/xp_presenter.sv
module xp_presenter #(
    parameter int SRC_W   = 24,
    parameter int PRIO_W  = 8,
    parameter int IPI_SRC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dlv_valid,
    input  logic [SRC_W-1:0]          dlv_src,
    input  logic [PRIO_W-1:0]         dlv_prio,
    output logic                      dlv_ack,
    output logic                      dlv_nak,
    output logic                      rej_valid,
    output logic [SRC_W-1:0]          rej_src,
    input  logic                      cmd_valid,
    input  logic [2:0]                cmd_op,
    input  logic [PRIO_W+SRC_W-1:0]   cmd_data,
    output logic                      rsp_valid,
    output logic [PRIO_W+SRC_W-1:0]   rsp_word,
    output logic [PRIO_W-1:0]         rsp_mfrr,
    output logic                      eoi_valid,
    output logic [SRC_W-1:0]          eoi_src,
    output logic                      resend_req,
    output logic                      irq_out
);
    import xp_pkg::*;

    localparam int WORD_W = PRIO_W + SRC_W;
    localparam logic [PRIO_W-1:0] PRIO_LOW = '1;
    localparam logic [SRC_W-1:0]  IPI_NUM  = SRC_W'(IPI_SRC);

    typedef struct packed {
        logic [PRIO_W-1:0] cppr;
        logic [SRC_W-1:0]  xisr;
        logic [PRIO_W-1:0] pprio;
        logic [PRIO_W-1:0] mfrr;
        logic              own;
        logic              irq;
        logic              ack;
        logic              nak;
        logic              rej_v;
        logic [SRC_W-1:0]  rej_s;
        logic              rsp_v;
        logic [WORD_W-1:0] rsp_w;
        logic [PRIO_W-1:0] rsp_m;
        logic              eoi_v;
        logic [SRC_W-1:0]  eoi_s;
        logic              rsd;
    } xp_state_t;

    xp_state_t st_d, st_q;
    xp_op_e    op;
    logic      slot_busy;
    logic      take;
    logic      ipi_fire;
    logic [PRIO_W-1:0] ipi_req_sel;
    logic [PRIO_W-1:0] ipi_proc_sel;
    logic [PRIO_W-1:0] cmd_prio_val;
    logic [PRIO_W-1:0] cmd_top_val;

    assign op           = xp_op_e'(cmd_op);
    assign slot_busy    = st_q.xisr != '0;
    assign cmd_prio_val = cmd_data[PRIO_W-1:0];
    assign cmd_top_val  = cmd_data[WORD_W-1:SRC_W];

    always_comb begin
        ipi_req_sel  = st_q.mfrr;
        ipi_proc_sel = st_q.cppr;
        case (op)
            XP_OP_SET_REQ:  ipi_req_sel  = cmd_prio_val;
            XP_OP_SET_PRIO: ipi_proc_sel = cmd_prio_val;
            XP_OP_EOI:      ipi_proc_sel = cmd_top_val;
            default: ;
        endcase
    end

    xp_deliver_judge #(.PRIO_W(PRIO_W)) i_judge (
        .offer_prio (dlv_prio),
        .proc_prio  (st_q.cppr),
        .slot_busy  (slot_busy),
        .slot_prio  (st_q.pprio),
        .take       (take)
    );

    xp_ipi_eval #(.PRIO_W(PRIO_W)) i_ipi (
        .req_prio  (ipi_req_sel),
        .proc_prio (ipi_proc_sel),
        .slot_busy (slot_busy),
        .slot_prio (st_q.pprio),
        .fire      (ipi_fire)
    );

    always_comb begin
        st_d       = st_q;
        st_d.ack   = 1'b0;
        st_d.nak   = 1'b0;
        st_d.rej_v = 1'b0;
        st_d.rej_s = '0;
        st_d.rsp_v = 1'b0;
        st_d.rsp_w = '0;
        st_d.rsp_m = '0;
        st_d.eoi_v = 1'b0;
        st_d.eoi_s = '0;
        st_d.rsd   = 1'b0;

        if (cmd_valid) begin
            case (op)
                XP_OP_SET_PRIO: begin
                    st_d.cppr = cmd_prio_val;
                    if (cmd_prio_val < st_q.cppr) begin
                        if (slot_busy && (cmd_prio_val <= st_q.pprio)) begin
                            st_d.xisr  = '0;
                            st_d.pprio = PRIO_LOW;
                            st_d.irq   = 1'b0;
                            st_d.own   = 1'b0;
                            if (st_q.own) begin
                                st_d.rej_v = 1'b1;
                                st_d.rej_s = st_q.xisr;
                            end
                        end
                    end else if (!slot_busy) begin
                        st_d.rsd = 1'b1;
                        if (ipi_fire) begin
                            st_d.xisr  = IPI_NUM;
                            st_d.pprio = ipi_req_sel;
                            st_d.own   = 1'b0;
                            st_d.irq   = 1'b1;
                        end
                    end
                end
                XP_OP_SET_REQ: begin
                    st_d.mfrr = cmd_prio_val;
                    if (ipi_fire) begin
                        if (slot_busy && st_q.own) begin
                            st_d.rej_v = 1'b1;
                            st_d.rej_s = st_q.xisr;
                        end
                        st_d.xisr  = IPI_NUM;
                        st_d.pprio = ipi_req_sel;
                        st_d.own   = 1'b0;
                        st_d.irq   = 1'b1;
                    end
                end
                XP_OP_ACCEPT: begin
                    st_d.rsp_v = 1'b1;
                    st_d.rsp_w = {st_q.cppr, st_q.xisr};
                    st_d.cppr  = st_q.pprio;
                    st_d.xisr  = '0;
                    st_d.pprio = PRIO_LOW;
                    st_d.own   = 1'b0;
                    st_d.irq   = 1'b0;
                end
                XP_OP_EOI: begin
                    st_d.cppr  = cmd_top_val;
                    st_d.eoi_v = 1'b1;
                    st_d.eoi_s = cmd_data[SRC_W-1:0];
                    if (!slot_busy) begin
                        st_d.rsd = 1'b1;
                        if (ipi_fire) begin
                            st_d.xisr  = IPI_NUM;
                            st_d.pprio = ipi_req_sel;
                            st_d.own   = 1'b0;
                            st_d.irq   = 1'b1;
                        end
                    end
                end
                XP_OP_POLL: begin
                    st_d.rsp_v = 1'b1;
                    st_d.rsp_w = {st_q.cppr, st_q.xisr};
                    st_d.rsp_m = st_q.mfrr;
                end
                default: ;
            endcase
            if (dlv_valid) begin
                st_d.nak = 1'b1;
            end
        end else if (dlv_valid) begin
            if (take) begin
                st_d.ack = 1'b1;
                if (slot_busy && st_q.own) begin
                    st_d.rej_v = 1'b1;
                    st_d.rej_s = st_q.xisr;
                end
                st_d.xisr  = dlv_src;
                st_d.pprio = dlv_prio;
                st_d.own   = 1'b1;
                st_d.irq   = 1'b1;
            end else begin
                st_d.nak = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.pprio <= PRIO_LOW;
            st_q.mfrr  <= PRIO_LOW;
        end else begin
            st_q <= st_d;
        end
    end

    assign dlv_ack    = st_q.ack;
    assign dlv_nak    = st_q.nak;
    assign rej_valid  = st_q.rej_v;
    assign rej_src    = st_q.rej_s;
    assign rsp_valid  = st_q.rsp_v;
    assign rsp_word   = st_q.rsp_w;
    assign rsp_mfrr   = st_q.rsp_m;
    assign eoi_valid  = st_q.eoi_v;
    assign eoi_src    = st_q.eoi_s;
    assign resend_req = st_q.rsd;
    assign irq_out    = st_q.irq;

    // R13: one reply per delivery, never both
    assert_one_reply_R13: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |=> (dlv_ack ^ dlv_nak));

    // R4: the line tracks slot occupancy
    assert_irq_tracks_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (st_q.xisr != '0));

    // R10: the inter-processor entry never goes back to the source layer
    assert_no_ipi_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid |-> (rej_src != IPI_NUM));

    // R2: refusal when not more favoured than the processor priority
    assert_refuse_weak_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && !cmd_valid && (dlv_prio >= st_q.cppr)) |=> dlv_nak);

    // R12: a command wins over a same-cycle delivery
    assert_cmd_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && cmd_valid) |=> dlv_nak);

    // R5: accept leaves the slot empty and the line low
    assert_accept_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd3) |=> (!irq_out && st_q.xisr == '0 && rsp_valid));

    // R11: poll alters nothing
    assert_poll_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd5) |=>
            ($stable(st_q.cppr) && $stable(st_q.xisr) && $stable(st_q.mfrr) && $stable(st_q.pprio)));
endmodule

// File: tb/test_xp_presenter.sv
`timescale 1ns/1ps
module test_xp_presenter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dlv_valid = 1'b0;
    logic [23:0] dlv_src = '0;
    logic [7:0]  dlv_prio = '0;
    logic        dlv_ack, dlv_nak, rej_valid;
    logic [23:0] rej_src;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [31:0] cmd_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_word;
    logic [7:0]  rsp_mfrr;
    logic        eoi_valid;
    logic [23:0] eoi_src;
    logic        resend_req, irq_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    xp_presenter i_xp_presenter (
        .clk(clk), .rst_n(rst_n),
        .dlv_valid(dlv_valid), .dlv_src(dlv_src), .dlv_prio(dlv_prio),
        .dlv_ack(dlv_ack), .dlv_nak(dlv_nak),
        .rej_valid(rej_valid), .rej_src(rej_src),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_word(rsp_word), .rsp_mfrr(rsp_mfrr),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src),
        .resend_req(resend_req), .irq_out(irq_out)
    );

    // reference state
    logic [7:0]  m_cppr, m_pp, m_mfrr;
    logic [23:0] m_xisr;
    logic        m_own, m_irq;
    logic        e_ack, e_nak, e_rejv, e_rspv, e_eoiv, e_rsd;
    logic [23:0] e_rejs, e_eois;
    logic [31:0] e_rspw;
    logic [7:0]  e_rspm;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic m_ipi(input logic [7:0] rq, input logic [7:0] cp, input bit may_reject);
        if ((rq < cp) && !((m_xisr != 0) && (m_pp <= rq))) begin
            if (may_reject && m_xisr != 0 && m_own) begin
                e_rejv = 1; e_rejs = m_xisr;
            end
            m_xisr = 24'd2; m_pp = rq; m_own = 0; m_irq = 1;
        end
    endtask

    task automatic step(input string req, input bit cv, input logic [2:0] op, input logic [31:0] d,
                        input bit dv, input logic [23:0] src, input logic [7:0] pr);
        logic [7:0] v;
        cmd_valid = cv; cmd_op = op; cmd_data = d;
        dlv_valid = dv; dlv_src = src; dlv_prio = pr;
        e_ack = 0; e_nak = 0; e_rejv = 0; e_rejs = 0; e_rspv = 0; e_rspw = 0;
        e_rspm = 0; e_eoiv = 0; e_eois = 0; e_rsd = 0;
        v = d[7:0];
        if (cv) begin
            if (dv) e_nak = 1;
            case (op)
                3'd1: begin
                    if (v < m_cppr) begin
                        if (m_xisr != 0 && v <= m_pp) begin
                            if (m_own) begin e_rejv = 1; e_rejs = m_xisr; end
                            m_xisr = 0; m_pp = 8'hFF; m_irq = 0; m_own = 0;
                        end
                        m_cppr = v;
                    end else begin
                        m_cppr = v;
                        if (m_xisr == 0) begin e_rsd = 1; m_ipi(m_mfrr, m_cppr, 1); end
                    end
                end
                3'd2: begin m_mfrr = v; m_ipi(m_mfrr, m_cppr, 1); end
                3'd3: begin
                    e_rspv = 1; e_rspw = {m_cppr, m_xisr};
                    m_cppr = m_pp; m_xisr = 0; m_pp = 8'hFF; m_own = 0; m_irq = 0;
                end
                3'd4: begin
                    m_cppr = d[31:24]; e_eoiv = 1; e_eois = d[23:0];
                    if (m_xisr == 0) begin e_rsd = 1; m_ipi(m_mfrr, m_cppr, 1); end
                end
                3'd5: begin e_rspv = 1; e_rspw = {m_cppr, m_xisr}; e_rspm = m_mfrr; end
                default: ;
            endcase
        end else if (dv) begin
            if (pr < m_cppr && !(m_xisr != 0 && m_pp <= pr)) begin
                e_ack = 1;
                if (m_xisr != 0 && m_own) begin e_rejv = 1; e_rejs = m_xisr; end
                m_xisr = src; m_pp = pr; m_own = 1; m_irq = 1;
            end else e_nak = 1;
        end
        @(negedge clk);
        chk(req, "ack", 32'(dlv_ack), 32'(e_ack));
        chk(req, "nak", 32'(dlv_nak), 32'(e_nak));
        chk(req, "rej_valid", 32'(rej_valid), 32'(e_rejv));
        chk(req, "rej_src", 32'(rej_src), 32'(e_rejs));
        chk(req, "rsp_valid", 32'(rsp_valid), 32'(e_rspv));
        chk(req, "rsp_word", rsp_word, e_rspw);
        chk(req, "rsp_mfrr", 32'(rsp_mfrr), 32'(e_rspm));
        chk(req, "eoi_valid", 32'(eoi_valid), 32'(e_eoiv));
        chk(req, "eoi_src", 32'(eoi_src), 32'(e_eois));
        chk(req, "resend", 32'(resend_req), 32'(e_rsd));
        chk(req, "irq", 32'(irq_out), 32'(m_irq));
        cmd_valid = 0; dlv_valid = 0;
    endtask

    task automatic cmd(input string req, input logic [2:0] op, input logic [31:0] d);
        step(req, 1, op, d, 0, 0, 0);
    endtask

    task automatic dlv(input string req, input logic [23:0] s, input logic [7:0] p);
        step(req, 0, 0, 0, 1, s, p);
    endtask

    initial begin
        m_cppr = 0; m_xisr = 0; m_pp = 8'hFF; m_mfrr = 8'hFF; m_own = 0; m_irq = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "irq after reset", 32'(irq_out), 32'h0);
        cmd("R1", 3'd5, 0);
        chk("R1", "reset word", rsp_word, 32'h0);
        chk("R1", "reset mfrr", 32'(rsp_mfrr), 32'hFF);
        cmd("R1", 3'd3, 0);
        cmd("R1", 3'd5, 0);
        chk("R1", "cppr after first accept", rsp_word, 32'hFF00_0000);

        dlv("R4", 24'h10, 8'd5);
        chk("R4", "line raised", 32'(irq_out), 32'h1);
        dlv("R3", 24'h11, 8'd5);
        dlv("R4", 24'h12, 8'd3);
        chk("R4", "displaced source", 32'(rej_src), 32'h10);
        cmd("R11", 3'd5, 0);
        chk("R11", "poll word", rsp_word, 32'hFF00_0012);
        cmd("R11", 3'd5, 0);
        chk("R11", "poll repeat", rsp_word, 32'hFF00_0012);
        cmd("R5", 3'd3, 0);
        chk("R5", "accept word", rsp_word, 32'hFF00_0012);
        cmd("R5", 3'd5, 0);
        chk("R5", "after accept", rsp_word, 32'h0300_0000);

        dlv("R2", 24'h20, 8'd3);
        dlv("R2", 24'h20, 8'd4);
        dlv("R4", 24'h20, 8'd2);
        cmd("R6", 3'd1, 32'h01);
        chk("R6", "cleared source rejected", 32'(rej_src), 32'h20);
        cmd("R7", 3'd1, 32'h01);
        chk("R7", "resend pulse", 32'(resend_req), 32'h1);
        cmd("R8", 3'd2, 32'h00);
        cmd("R8", 3'd5, 0);
        chk("R8", "ipi pending", rsp_word, 32'h0100_0002);
        dlv("R2", 24'h30, 8'd0);
        cmd("R7", 3'd1, 32'h80);
        dlv("R3", 24'h30, 8'h10);
        cmd("R8", 3'd2, 32'h40);
        cmd("R8", 3'd5, 0);
        chk("R8", "held ipi", rsp_word, 32'h8000_0002);
        chk("R11", "mfrr readback", 32'(rsp_mfrr), 32'h40);
        cmd("R6", 3'd1, 32'h90);
        cmd("R10", 3'd1, 32'h00);
        chk("R10", "ipi not rejected", 32'(rej_valid), 32'h0);
        cmd("R9", 3'd4, 32'h8000_0020);
        chk("R9", "eoi number", 32'(eoi_src), 32'h20);
        cmd("R9", 3'd5, 0);
        chk("R9", "ipi after eoi", rsp_word, 32'h8000_0002);
        dlv("R10", 24'h50, 8'h20);
        chk("R10", "ipi displaced quietly", 32'(rej_valid), 32'h0);
        cmd("R8", 3'd2, 32'h10);
        chk("R8", "source displaced by ipi", 32'(rej_src), 32'h50);
        step("R12", 1, 3'd5, 0, 1, 24'h60, 8'h00);
        chk("R12", "refused beside command", 32'(dlv_nak), 32'h1);
        cmd("R5", 3'd3, 0);
        cmd("R8", 3'd2, 32'hFF);
        cmd("R9", 3'd4, 32'hFF00_0002);

        // sweep of delivery priority against processor priority, empty and occupied
        for (int c = 0; c < 8; c++) begin
            for (int p = 0; p < 8; p++) begin
                cmd("R5", 3'd3, 0);
                cmd("R9", 3'd4, {8'(c), 24'h0});
                dlv("R2", 24'h100 + 24'(p), 8'(p));
                dlv("R3", 24'h200, 8'd3);
                cmd("R11", 3'd5, 0);
            end
        end
        // sweep of request priority against a fixed processor priority
        for (int q = 0; q < 8; q++) begin
            cmd("R5", 3'd3, 0);
            cmd("R9", 3'd4, 32'h0400_0000);
            dlv("R4", 24'h300, 8'd2);
            cmd("R8", 3'd2, 32'(q));
            cmd("R11", 3'd5, 0);
            cmd("R8", 3'd2, 32'hFF);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule